// File: doc/BRIEF.md
# Quad-Data-Rate Burst-of-Four Synchronous SRAM Port

This block models a synchronous static memory with a separate read port and write port. Both ports share one address bus and each has its own active-low select. Commands and addresses are sampled once per memory cycle. Data moves on both halves of that cycle. Each accepted request moves a burst of four words.

The block runs from a single fast clock. Every rising edge of that clock is one half-cycle of the memory clock. The input `k_phase` is high on the edge that stands for the rising edge of K, and low on the edge that stands for the rising edge of K#. The environment must toggle `k_phase` on every edge. The memory is organised as aligned groups of four words. A burst starting at address A visits A, A+1, A+2 and A+3, where the offset wraps inside the low two address bits and the upper bits stay fixed.

Write data beats are stored directly into the array on their edges. A read takes a snapshot of its whole four-word group on the request edge. It then moves the words through a stage register and a shift register to the registered output. `rdata_oe` is the tri-state enable that a pad ring uses to drive the read data.

Each port is controlled by a small state machine:
- Write machine states: `WR_IDLE`, `WR_LEAD`, `WR_BEAT0` to `WR_BEAT3`.
  - Transitions: idle→lead on an accepted write; lead→beat0; beat0→beat1→beat2→beat3.
  - From beat3 it goes to beat0 if a second write is pending, otherwise to idle.
- Read machine states: `RD_IDLE`, `RD_LEAD`, `RD_LOAD`, `RD_BEAT0` to `RD_BEAT3`.
  - Transitions: idle→lead on an accepted read; lead→load; load→beat0; beat0→beat1→beat2→beat3.
  - From beat3 it goes to beat0 if a read is pending, to lead if a read is accepted on that edge, otherwise to idle.

Top module: `qdr4_sram`

## Requirements
- R1: While `rst_n` is low and right after its release, `rdata_oe` is 0 and `rdata` is 0. No request is in flight after reset.
- R2: A write is accepted on an edge with `k_phase`=1 and `wr_sel_n`=0. The address on `addr` is latched on that same edge.
- R3: For a write accepted on edge e, `wdata` is stored on edges e+2, e+3, e+4 and e+5, in that order, as burst words 0 to 3.
- R4: For a read accepted on edge e, burst word 0 is on `rdata` after edge e+3. Words 1, 2 and 3 follow after edges e+4, e+5 and e+6. `rdata_oe` is 1 for exactly those four half-cycles.
- R5: Burst word k has address {A[ADDR_W-1:2], (A[1:0]+k) mod 4}. The offset wraps inside the aligned group of four.
- R6: A request on the K edge directly after an accepted request of the same type is ignored. A request two K edges later is accepted. Two such reads give eight contiguous output words, and two such writes give eight contiguous input beats.
- R7: With each write beat, `bw_n` bit b low stores byte b (`wdata` bits 8b+7 down to 8b). Bit b high leaves that byte of that word unchanged.
- R8: A read and a write to the same burst address accepted on the same edge return the data held before the write.
- R9: While both selects are high, `wdata`, `bw_n` and `addr` have no effect, `rdata_oe` stays 0 and the array contents are held.
- R10: A select asserted on an edge with `k_phase`=0 starts no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; each rising edge is one half memory cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| k_phase | input | 1 | 1 on the K-rise edge, 0 on the K#-rise edge |
| rd_sel_n | input | 1 | Active-low read port select |
| wr_sel_n | input | 1 | Active-low write port select |
| addr | input | ADDR_W | Burst start address, sampled on accepted K edges |
| wdata | input | DATA_W | Write data, one word per write beat |
| bw_n | input | DATA_W/BYTE_W | Active-low byte write enables, one per byte of a beat |
| rdata | output | DATA_W | Registered read data |
| rdata_oe | output | 1 | Output enable for read data (1 = drive) |

## Verification
Results depend on the request edge e. Write beats are taken at e+2 to e+5. Read words appear after e+3 to e+6, and the enable drops after e+7 unless another read continues the stream. The bench counts edges from the request. It drives inputs on the falling clock edge, so at the falling edge before edge e+s it sees what edge e+s-1 produced. Read words are therefore compared at s=4 to 7, and the released enable is checked at s=8. Back-to-back streams extend this window to s=4 to 11. Effects of writes are confirmed by later reads through the port.

// File: rtl/qdr4_pkg.sv
package qdr4_pkg;

    localparam int BURST_LEN = 4;

    typedef enum logic [2:0] {
        WR_IDLE,
        WR_LEAD,
        WR_BEAT0,
        WR_BEAT1,
        WR_BEAT2,
        WR_BEAT3
    } wr_state_e;

    typedef enum logic [2:0] {
        RD_IDLE,
        RD_LEAD,
        RD_LOAD,
        RD_BEAT0,
        RD_BEAT1,
        RD_BEAT2,
        RD_BEAT3
    } rd_state_e;

    // offset of burst word 'step' inside an aligned group of four
    function automatic logic [1:0] lane_of(input logic [1:0] start, input logic [1:0] step);
        return start + step;
    endfunction

endpackage

// File: rtl/qdr4_req_gate.sv
// Accepts a request on a K edge unless the previous K edge accepted one.
module qdr4_req_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic k_phase,
    input  logic sel_n,
    output logic accept
);

    logic blocked;

    assign accept = k_phase & ~sel_n & ~blocked;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blocked <= 1'b0;
        end else if (k_phase) begin
            blocked <= accept;
        end
    end

endmodule

// File: rtl/qdr4_array.sv
// Storage: byte-masked single-word write port, whole-group read port.
module qdr4_array #(
    parameter  int ADDR_W = 6,
    parameter  int DATA_W = 16,
    parameter  int BYTE_W = 8,
    localparam int NBYTE  = DATA_W / BYTE_W,
    localparam int ROW_W  = ADDR_W - 2,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic                   clk,
    input  logic                   we,
    input  logic [ADDR_W-1:0]      waddr,
    input  logic [DATA_W-1:0]      wdata,
    input  logic [NBYTE-1:0]       wbe_n,
    input  logic [ROW_W-1:0]       rrow,
    output logic [3:0][DATA_W-1:0] row_q
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int b = 0; b < NBYTE; b++) begin
                if (!wbe_n[b]) begin
                    mem[waddr][b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
                end
            end
        end
    end

    for (genvar l = 0; l < 4; l++) begin : g_lane
        assign row_q[l] = mem[{rrow, 2'(l)}];
    end

endmodule

// File: rtl/qdr4_wr_ctl.sv
// Write burst sequencer: one lead half-cycle, then four data beats.
module qdr4_wr_ctl
    import qdr4_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] addr,
    output logic              beat_we,
    output logic [ADDR_W-1:0] beat_addr
);

    wr_state_e         state, nxt;
    logic [ADDR_W-1:0] base, pend_addr;
    logic              pend;
    logic [1:0]        step;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= WR_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            WR_IDLE:  nxt = accept ? WR_LEAD : WR_IDLE;
            WR_LEAD:  nxt = WR_BEAT0;
            WR_BEAT0: nxt = WR_BEAT1;
            WR_BEAT1: nxt = WR_BEAT2;
            WR_BEAT2: nxt = WR_BEAT3;
            WR_BEAT3: nxt = pend ? WR_BEAT0 : WR_IDLE;
            default:  nxt = WR_IDLE;
        endcase
    end

    always_comb begin
        beat_we = 1'b0;
        step    = 2'd0;
        unique case (state)
            WR_BEAT0: begin beat_we = 1'b1; step = 2'd0; end
            WR_BEAT1: begin beat_we = 1'b1; step = 2'd1; end
            WR_BEAT2: begin beat_we = 1'b1; step = 2'd2; end
            WR_BEAT3: begin beat_we = 1'b1; step = 2'd3; end
            default:  begin beat_we = 1'b0; step = 2'd0; end
        endcase
    end

    assign beat_addr = {base[ADDR_W-1:2], lane_of(base[1:0], step)};

    // a request accepted during a burst waits until the last beat
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base      <= '0;
            pend_addr <= '0;
            pend      <= 1'b0;
        end else begin
            if (state == WR_BEAT3 && pend) begin
                base <= pend_addr;
                pend <= 1'b0;
            end
            if (accept && state == WR_IDLE) begin
                base <= addr;
            end else if (accept) begin
                pend      <= 1'b1;
                pend_addr <= addr;
            end
        end
    end

endmodule

// File: rtl/qdr4_rd_ctl.sv
// Read burst sequencer: snapshot, stage, shift out four words.
module qdr4_rd_ctl
    import qdr4_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   accept,
    input  logic [1:0]             start_lane,
    input  logic [3:0][DATA_W-1:0] row_q,
    output logic [DATA_W-1:0]      rdata,
    output logic                   rdata_oe
);

    rd_state_e                state, nxt;
    logic [3:0][DATA_W-1:0]   stg;
    logic [3:0][DATA_W-1:0]   sh;
    logic [1:0]               stg_lane;
    logic                     pend;
    logic                     beat, load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RD_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RD_IDLE:  nxt = accept ? RD_LEAD : RD_IDLE;
            RD_LEAD:  nxt = RD_LOAD;
            RD_LOAD:  nxt = RD_BEAT0;
            RD_BEAT0: nxt = RD_BEAT1;
            RD_BEAT1: nxt = RD_BEAT2;
            RD_BEAT2: nxt = RD_BEAT3;
            RD_BEAT3: nxt = pend ? RD_BEAT0 : (accept ? RD_LEAD : RD_IDLE);
            default:  nxt = RD_IDLE;
        endcase
    end

    always_comb begin
        beat = 1'b0;
        load = 1'b0;
        unique case (state)
            RD_LOAD:  load = 1'b1;
            RD_BEAT0: beat = 1'b1;
            RD_BEAT1: beat = 1'b1;
            RD_BEAT2: beat = 1'b1;
            RD_BEAT3: begin beat = 1'b1; load = pend; end
            default:  begin beat = 1'b0; load = 1'b0; end
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata    <= '0;
            rdata_oe <= 1'b0;
        end else begin
            rdata_oe <= beat;
            if (beat) begin
                rdata <= sh[0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (accept && state != RD_IDLE && state != RD_BEAT3) begin
            pend <= 1'b1;
        end else if (state == RD_BEAT3) begin
            pend <= 1'b0;
        end
    end

    // data path: snapshot taken before any same-edge write lands
    always_ff @(posedge clk) begin
        if (accept) begin
            stg      <= row_q;
            stg_lane <= start_lane;
        end
        if (load) begin
            for (int k = 0; k < 4; k++) begin
                sh[k] <= stg[lane_of(stg_lane, 2'(k))];
            end
        end else if (beat) begin
            for (int k = 0; k < 3; k++) begin
                sh[k] <= sh[k+1];
            end
        end
    end

endmodule

// File: rtl/qdr4_sram.sv
module qdr4_sram #(
    parameter  int ADDR_W = 6,
    parameter  int DATA_W = 16,
    parameter  int BYTE_W = 8,
    localparam int NBYTE  = DATA_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              k_phase,
    input  logic              rd_sel_n,
    input  logic              wr_sel_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NBYTE-1:0]  bw_n,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe
);

    logic                   rd_acc, wr_acc;
    logic                   beat_we;
    logic [ADDR_W-1:0]      beat_addr;
    logic [3:0][DATA_W-1:0] row_q;

    qdr4_req_gate u_rd_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .k_phase (k_phase),
        .sel_n   (rd_sel_n),
        .accept  (rd_acc)
    );

    qdr4_req_gate u_wr_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .k_phase (k_phase),
        .sel_n   (wr_sel_n),
        .accept  (wr_acc)
    );

    qdr4_wr_ctl #(.ADDR_W(ADDR_W)) u_wr_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (wr_acc),
        .addr      (addr),
        .beat_we   (beat_we),
        .beat_addr (beat_addr)
    );

    qdr4_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_array (
        .clk   (clk),
        .we    (beat_we),
        .waddr (beat_addr),
        .wdata (wdata),
        .wbe_n (bw_n),
        .rrow  (addr[ADDR_W-1:2]),
        .row_q (row_q)
    );

    qdr4_rd_ctl #(.DATA_W(DATA_W)) u_rd_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (rd_acc),
        .start_lane (addr[1:0]),
        .row_q      (row_q),
        .rdata      (rdata),
        .rdata_oe   (rdata_oe)
    );

endmodule

// File: rtl/qdr4_sram_chk.sv
module qdr4_sram_chk #(
    parameter int QUIET = 8
) (
    input logic clk,
    input logic rst_n,
    input logic k_phase,
    input logic rd_sel_n,
    input logic rdata_oe
);

    // independent model of which read requests the port should take
    logic       mdl_blk;
    logic       mdl_acc;
    logic [3:0] since_acc;

    assign mdl_acc = k_phase && !rd_sel_n && !mdl_blk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdl_blk   <= 1'b0;
            since_acc <= 4'hF;
        end else begin
            if (k_phase) begin
                mdl_blk <= mdl_acc;
            end
            if (mdl_acc) begin
                since_acc <= 4'h0;
            end else if (since_acc != 4'hF) begin
                since_acc <= since_acc + 4'h1;
            end
        end
    end

    // R1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (!rdata_oe)
                else $error("R1: read drive active in reset");
        end
    end

    a_r4_read_window: assert property (@(posedge clk) disable iff (!rst_n)
        mdl_acc |-> ##4 rdata_oe ##1 rdata_oe ##1 rdata_oe ##1 rdata_oe)
        else $error("R4: read window not four half-cycles at latency 1.5");

    a_r6_second_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        mdl_acc ##2 (k_phase && !rd_sel_n) ##2 !mdl_acc |-> ##4 !rdata_oe)
        else $error("R6: ignored read extended the output window");

    a_r9_idle_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (since_acc >= 4'(QUIET)) |-> !rdata_oe)
        else $error("R9: read drive active without a read");

endmodule

bind qdr4_sram qdr4_sram_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .k_phase  (k_phase),
    .rd_sel_n (rd_sel_n),
    .rdata_oe (rdata_oe)
);

// File: tb/qdr4_sram_bench.sv
`timescale 1ns/1ps
module qdr4_sram_bench;

    localparam int AW = 6;
    localparam int DW = 16;
    localparam int NB = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          k_phase = 1'b0;
    logic          rd_sel_n = 1'b1;
    logic          wr_sel_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [NB-1:0] bw_n = '1;
    logic [DW-1:0] rdata;
    logic          rdata_oe;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [DW-1:0] ref_mem [64];

    always #2 clk = ~clk;

    qdr4_sram #(.ADDR_W(AW), .DATA_W(DW), .BYTE_W(8)) u_qdr4_sram (
        .clk      (clk),
        .rst_n    (rst_n),
        .k_phase  (k_phase),
        .rd_sel_n (rd_sel_n),
        .wr_sel_n (wr_sel_n),
        .addr     (addr),
        .wdata    (wdata),
        .bw_n     (bw_n),
        .rdata    (rdata),
        .rdata_oe (rdata_oe)
    );

    task automatic chk(input string req, input string what,
                       input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    // next half-cycle: toggles the phase, deselects, puts junk on data pins
    task automatic nedge();
        @(negedge clk);
        k_phase  = ~k_phase;
        rd_sel_n = 1'b1;
        wr_sel_n = 1'b1;
        cyc++;
        wdata = 16'hA5C3 ^ 16'(cyc * 37);
        bw_n  = 2'(cyc);
        addr  = 6'(cyc * 5);
    endtask

    task automatic align();
        if (k_phase) nedge();
    endtask

    function automatic int wa(input logic [AW-1:0] a, input int k);
        return int'({a[AW-1:2], 2'(a[1:0] + 2'(k))});
    endfunction

    task automatic ref_wr(input logic [AW-1:0] a, input int k,
                          input logic [DW-1:0] d, input logic [NB-1:0] bn);
        for (int b = 0; b < NB; b++) begin
            if (!bn[b]) ref_mem[wa(a, k)][b*8 +: 8] = d[b*8 +: 8];
        end
    endtask

    // one isolated request (read, write or both) on a K edge
    task automatic op(input bit rd, input bit wr, input logic [AW-1:0] a,
                      input logic [63:0] d, input logic [7:0] bn, input string req);
        logic [DW-1:0] exp [4];
        for (int k = 0; k < 4; k++) exp[k] = ref_mem[wa(a, k)];
        align();
        for (int s = 0; s < 9; s++) begin
            nedge();
            if (s == 0) begin
                addr     = a;
                rd_sel_n = !rd;
                wr_sel_n = !wr;
            end
            if (wr && s >= 2 && s <= 5) begin
                wdata = d[(s-2)*16 +: 16];
                bw_n  = bn[(s-2)*2 +: 2];
            end
            if (rd && s >= 4 && s <= 7) begin
                chk(req, "read enable", 16'(rdata_oe), 16'd1);
                chk(req, "read word", rdata, exp[s-4]);
            end
            if (rd && s == 8) chk(req, "enable released", 16'(rdata_oe), 16'd0);
        end
        if (wr) begin
            for (int k = 0; k < 4; k++) ref_wr(a, k, d[k*16 +: 16], bn[k*2 +: 2]);
        end
    endtask

    task automatic t_reset();
        for (int i = 0; i < 4; i++) begin
            nedge();
            chk("R1", "enable in reset", 16'(rdata_oe), 16'd0);
        end
        rst_n = 1'b1;
        nedge();
        nedge();
        chk("R1", "enable after reset", 16'(rdata_oe), 16'd0);
        chk("R1", "data after reset", rdata, 16'd0);
    endtask

    task automatic t_fill();
        for (int r = 0; r < 16; r++) begin
            logic [63:0] d;
            for (int k = 0; k < 4; k++) d[k*16 +: 16] = 16'((r * 4 + k) * 613 + 7);
            op(1'b0, 1'b1, 6'(r * 4), d, 8'h00, "R2");
        end
    endtask

    task automatic t_basic();
        op(1'b1, 1'b0, 6'h08, 64'h0, 8'h00, "R4");
        op(1'b0, 1'b1, 6'h24, 64'h4444_3333_2222_1111, 8'h00, "R2");
        op(1'b1, 1'b0, 6'h24, 64'h0, 8'h00, "R3");
        chk("R3", "beat order word2", ref_mem[6'h26], 16'h3333);
    endtask

    task automatic t_wrap();
        op(1'b0, 1'b1, 6'h1E, 64'hDDDD_CCCC_BBBB_AAAA, 8'h00, "R5");
        chk("R5", "wrapped word3 address", ref_mem[6'h1D], 16'hDDDD);
        op(1'b1, 1'b0, 6'h1D, 64'h0, 8'h00, "R5");
    endtask

    task automatic t_mask();
        // beat0 none, beat1 both, beat2 high byte only, beat3 low byte only
        op(1'b0, 1'b1, 6'h30, 64'h9988_7766_5544_3322, 8'b10_01_00_11, "R7");
        op(1'b1, 1'b0, 6'h30, 64'h0, 8'h00, "R7");
    endtask

    task automatic t_same_edge();
        op(1'b1, 1'b1, 6'h11, 64'h0F0F_1E1E_2D2D_3C3C, 8'h00, "R8");
        op(1'b1, 1'b0, 6'h11, 64'h0, 8'h00, "R8");
    endtask

    task automatic t_idle();
        align();
        for (int i = 0; i < 24; i++) begin
            nedge();
            bw_n = 2'b00;
            chk("R9", "enable while deselected", 16'(rdata_oe), 16'd0);
        end
        op(1'b1, 1'b0, 6'h00, 64'h0, 8'h00, "R9");
        op(1'b1, 1'b0, 6'h30, 64'h0, 8'h00, "R9");
    endtask

    task automatic t_kbar();
        align();
        nedge();
        nedge();
        rd_sel_n = 1'b0;
        wr_sel_n = 1'b0;
        addr     = 6'h3C;
        for (int i = 0; i < 10; i++) begin
            nedge();
            wdata = 16'hFFFF;
            bw_n  = 2'b00;
            chk("R10", "enable after K# select", 16'(rdata_oe), 16'd0);
        end
        op(1'b1, 1'b0, 6'h3C, 64'h0, 8'h00, "R10");
    endtask

    task automatic t_b2b_read();
        logic [DW-1:0] ea [4];
        logic [DW-1:0] eb [4];
        for (int k = 0; k < 4; k++) begin
            ea[k] = ref_mem[wa(6'h04, k)];
            eb[k] = ref_mem[wa(6'h2B, k)];
        end
        align();
        for (int s = 0; s < 13; s++) begin
            nedge();
            if (s == 0) begin rd_sel_n = 1'b0; addr = 6'h04; end
            if (s == 2) begin rd_sel_n = 1'b0; addr = 6'h28; end
            if (s == 4) begin rd_sel_n = 1'b0; addr = 6'h2B; end
            if (s >= 4 && s <= 11) chk("R6", "stream enable", 16'(rdata_oe), 16'd1);
            if (s >= 4 && s <= 7)  chk("R6", "first burst word", rdata, ea[s-4]);
            if (s >= 8 && s <= 11) chk("R6", "second burst word", rdata, eb[s-8]);
            if (s == 12) chk("R6", "stream end", 16'(rdata_oe), 16'd0);
        end
    endtask

    task automatic t_b2b_write();
        logic [63:0] da = 64'h1004_1003_1002_1001;
        logic [63:0] db = 64'h2004_2003_2002_2001;
        align();
        for (int s = 0; s < 11; s++) begin
            nedge();
            if (s == 0) begin wr_sel_n = 1'b0; addr = 6'h14; end
            if (s == 2) begin wr_sel_n = 1'b0; addr = 6'h38; end
            if (s == 4) begin wr_sel_n = 1'b0; addr = 6'h0A; end
            if (s >= 2 && s <= 5) begin wdata = da[(s-2)*16 +: 16]; bw_n = 2'b00; end
            if (s >= 6 && s <= 9) begin wdata = db[(s-6)*16 +: 16]; bw_n = 2'b00; end
        end
        for (int k = 0; k < 4; k++) begin
            ref_wr(6'h14, k, da[k*16 +: 16], 2'b00);
            ref_wr(6'h0A, k, db[k*16 +: 16], 2'b00);
        end
        op(1'b1, 1'b0, 6'h14, 64'h0, 8'h00, "R6");
        op(1'b1, 1'b0, 6'h0A, 64'h0, 8'h00, "R6");
        op(1'b1, 1'b0, 6'h38, 64'h0, 8'h00, "R6");
    endtask

    initial begin
        for (int i = 0; i < 64; i++) ref_mem[i] = '0;
        t_reset();
        t_fill();
        t_basic();
        t_wrap();
        t_mask();
        t_same_edge();
        t_idle();
        t_kbar();
        t_b2b_read();
        t_b2b_write();
        nedge();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule